// File: doc/BRIEF.md
# Transformer Flux-Balance PI Compensator

This block keeps the magnetizing current of a full-bridge transformer centred on zero, so no series DC-blocking capacitor is needed. In each switching period it takes two peak samples of the primary current, one from each power-transfer half. It halves their difference to form an offset error, and passes that error through a slow proportional-integral law. The output is a small signed duty correction. The correction then skews the duties of the two half-cycles of the following period, so that their volt-seconds match.

The voltage loop supplies the nominal duty. The peak detector and converter supply the sample strobes, a period marker and an enable. The block returns the two half-cycle duties that the PWM stage uses. The correction is clamped to a small fraction of the nominal duty, so output regulation is never dominated by the balancing loop. The integrator is clamped to the same bound, so it cannot wind up.

Top module: `fb_flux_balance`

## Requirements
- R1: An update happens only when `pk_second_vld` arrives after a `pk_first_vld` in the same period. Its error is floor((first − second)/2), taken with an arithmetic shift of the signed difference.
- R2: If a period closes without a second-half sample, or if a second-half sample arrives with no first-half sample pending, the correction is left unchanged.
- R3: At an update, acc += KI·e and correction = floor(KP·e / 2^FRAC) + floor(acc / 2^FRAC). The defaults are KP = 23992, KI = 22, FRAC = 20, which together realise 0.0229·(z−0.9991)/(z−1).
- R4: The correction is clamped to ±floor(duty_nom/20), with `duty_nom` taken at the update.
- R5: The integrator is clamped to ±floor(duty_nom/20)·2^FRAC (anti-windup). After a long one-sided error, a reversal takes effect from the clamped value.
- R6: Split mode (`mode_sel` = 0): with h = correction >>> 1, first duty = nominal − h and second duty = nominal + h.
- R7: Whole mode (`mode_sel` = 1): the first duty equals the nominal duty and the second duty = nominal + correction.
- R8: `mode_sel` is sampled only when `period_start` is high. After reset the block is in split mode.
- R9: While `conv_en` is low, the integrator and the correction are zero and samples are ignored. A disable in the same cycle as a second-half strobe cancels that update.
- R10: Both output duties saturate to the range 0 … 2^DW−1.
- R11: While reset is high both duties read 0. After reset, with zero correction, both equal the nominal duty.
- R12: A new correction appears on the duty outputs two clock edges after the second-half strobe is sampled. A change of `duty_nom` appears after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Converter running; low clears the compensator |
| period_start | input | 1 | Marks the start of a switching period |
| mode_sel | input | 1 | 0 split correction, 1 whole correction on second half |
| pk_first | input | CW (12) | Primary peak sample, first power transfer |
| pk_first_vld | input | 1 | Strobe for `pk_first` |
| pk_second | input | CW (12) | Primary peak sample, second power transfer |
| pk_second_vld | input | 1 | Strobe for `pk_second` |
| duty_nom | input | DW (12) | Nominal duty from the voltage loop |
| duty_first | output | DW (12) | Corrected duty of the first half-cycle |
| duty_second | output | DW (12) | Corrected duty of the second half-cycle |

## Verification
Two events can fall in the same clock cycle: a compensator update triggered by the second-half strobe, and the clear caused by `conv_en` falling. The bench raises both in one cycle after a correction has already built up. It expects the clear to win, so both duties settle at the nominal value. A later enabled period must then start from a zero integrator. A period-start marker that lands between the two samples is also driven. It must discard the pending first sample and leave the duties unchanged.

// File: rtl/fb_pkg.sv
package fb_pkg;

    localparam int FB_ERR_W = 24;

    typedef enum logic {
        APPLY_SPLIT = 1'b0,
        APPLY_WHOLE = 1'b1
    } apply_mode_e;

    typedef struct packed {
        logic                       vld;
        logic signed [FB_ERR_W-1:0] err;
    } fb_update_t;

    function automatic logic signed [63:0] clamp_sym(
        input logic signed [63:0] v,
        input logic signed [63:0] lim
    );
        if (v > lim)       return lim;
        else if (v < -lim) return -lim;
        else               return v;
    endfunction

endpackage

// File: rtl/fb_err_capture.sv
module fb_err_capture
    import fb_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          prd_start,
    input  logic [CW-1:0] pk1,
    input  logic          pk1_vld,
    input  logic [CW-1:0] pk2,
    input  logic          pk2_vld,
    output fb_update_t    upd
);
    logic          pend_q;
    logic [CW-1:0] pk1_q;
    logic signed [CW:0] diff;
    logic signed [CW:0] half_diff;

    always_comb begin
        diff      = $signed({1'b0, pk1_q}) - $signed({1'b0, pk2});
        half_diff = diff >>> 1;
        upd.vld   = en && pend_q && pk2_vld;
        upd.err   = FB_ERR_W'(half_diff);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pend_q <= 1'b0;
            pk1_q  <= '0;
        end else if (pk1_vld) begin
            pend_q <= 1'b1;
            pk1_q  <= pk1;
        end else if (prd_start || upd.vld) begin
            pend_q <= 1'b0;
        end
    end

    AST_ONE_UPDATE_PER_PAIR: assert property (@(posedge clk) disable iff (rst)
        (upd.vld && !pk1_vld) |=> !upd.vld); // R1

endmodule

// File: rtl/fb_pi_core.sv
module fb_pi_core
    import fb_pkg::*;
#(
    parameter int DW      = 12,
    parameter int FRAC    = 20,
    parameter int KP      = 23992,
    parameter int KI      = 22,
    parameter int LIM_DIV = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  fb_update_t           upd,
    input  logic [DW-1:0]        duty_nom,
    output logic signed [DW:0]   corr
);
    localparam int ACC_W = DW + FRAC + 2;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [DW:0]      corr_q;
    logic signed [63:0]      err_w, lim_w, lim_acc, p_w;
    logic signed [63:0]      acc_sum, acc_nx, corr_nx;

    always_comb begin
        err_w   = 64'(upd.err);
        lim_w   = signed'(64'(duty_nom / DW'(LIM_DIV)));
        lim_acc = lim_w <<< FRAC;
        p_w     = (err_w * 64'(KP)) >>> FRAC;
        acc_sum = 64'(acc_q) + err_w * 64'(KI);
        acc_nx  = clamp_sym(acc_sum, lim_acc);
        corr_nx = clamp_sym(p_w + (acc_nx >>> FRAC), lim_w);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc_q  <= '0;
            corr_q <= '0;
        end else if (upd.vld) begin
            acc_q  <= ACC_W'(acc_nx);
            corr_q <= (DW+1)'(corr_nx);
        end
    end

    assign corr = corr_q;

    AST_CORR_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (en && upd.vld) |=> (64'(corr_q) <= $past(lim_w) && 64'(corr_q) >= -$past(lim_w))); // R4
    AST_ACC_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (en && upd.vld) |=> (64'(acc_q) <= $past(lim_acc) && 64'(acc_q) >= -$past(lim_acc))); // R5
    AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (corr_q == '0 && acc_q == '0)); // R9
    AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (en && !upd.vld) |=> $stable(corr_q)); // R2

endmodule

// File: rtl/fb_duty_apply.sv
module fb_duty_apply
    import fb_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prd_start,
    input  apply_mode_e        mode_in,
    input  logic [DW-1:0]      duty_nom,
    input  logic signed [DW:0] corr,
    output logic [DW-1:0]      d1,
    output logic [DW-1:0]      d2
);
    localparam logic signed [DW+1:0] DMAX = (DW+2)'((1 << DW) - 1);

    apply_mode_e          mode_q;
    logic signed [DW:0]   half;
    logic signed [DW+1:0] nom_s, raw1, raw2;
    logic [DW-1:0]        d1_q, d2_q, sat1, sat2;

    always_comb begin
        half  = corr >>> 1;
        nom_s = $signed({2'b00, duty_nom});
        if (mode_q == APPLY_SPLIT) begin
            raw1 = nom_s - (DW+2)'(half);
            raw2 = nom_s + (DW+2)'(half);
        end else begin
            raw1 = nom_s;
            raw2 = nom_s + (DW+2)'(corr);
        end
        if (raw1 < 0)         sat1 = '0;
        else if (raw1 > DMAX) sat1 = '1;
        else                  sat1 = raw1[DW-1:0];
        if (raw2 < 0)         sat2 = '0;
        else if (raw2 > DMAX) sat2 = '1;
        else                  sat2 = raw2[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= APPLY_SPLIT;
            d1_q   <= '0;
            d2_q   <= '0;
        end else begin
            if (prd_start) mode_q <= mode_in;
            d1_q <= sat1;
            d2_q <= sat2;
        end
    end

    assign d1 = d1_q;
    assign d2 = d2_q;

    AST_WHOLE_FIRST_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        (mode_q == APPLY_WHOLE) |=> (d1_q == $past(duty_nom))); // R7
    AST_SPLIT_BALANCED: assert property (@(posedge clk) disable iff (rst)
        (mode_q == APPLY_SPLIT && !duty_nom[DW-1])
        |=> ((DW+1)'(d1_q) + (DW+1)'(d2_q) == {$past(duty_nom), 1'b0})); // R6

endmodule

// File: rtl/fb_flux_balance.sv
module fb_flux_balance
    import fb_pkg::*;
#(
    parameter int CW      = 12,
    parameter int DW      = 12,
    parameter int FRAC    = 20,
    parameter int KP      = 23992,
    parameter int KI      = 22,
    parameter int LIM_DIV = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_en,
    input  logic          period_start,
    input  logic          mode_sel,
    input  logic [CW-1:0] pk_first,
    input  logic          pk_first_vld,
    input  logic [CW-1:0] pk_second,
    input  logic          pk_second_vld,
    input  logic [DW-1:0] duty_nom,
    output logic [DW-1:0] duty_first,
    output logic [DW-1:0] duty_second
);
    fb_update_t         upd;
    logic signed [DW:0] corr;

    fb_err_capture #(.CW(CW)) u_cap (
        .clk(clk), .rst(rst), .en(conv_en), .prd_start(period_start),
        .pk1(pk_first), .pk1_vld(pk_first_vld),
        .pk2(pk_second), .pk2_vld(pk_second_vld), .upd(upd)
    );

    fb_pi_core #(.DW(DW), .FRAC(FRAC), .KP(KP), .KI(KI), .LIM_DIV(LIM_DIV)) u_pi (
        .clk(clk), .rst(rst), .en(conv_en), .upd(upd),
        .duty_nom(duty_nom), .corr(corr)
    );

    fb_duty_apply #(.DW(DW)) u_app (
        .clk(clk), .rst(rst), .prd_start(period_start),
        .mode_in(apply_mode_e'(mode_sel)), .duty_nom(duty_nom), .corr(corr),
        .d1(duty_first), .d2(duty_second)
    );

endmodule

// File: tb/sim_fb_flux_balance.sv
module sim_fb_flux_balance;
    localparam int FRAC = 20;
    localparam int KP   = 23992;
    localparam int KI   = 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_en = 1'b0, period_start = 1'b0, mode_sel = 1'b0;
    logic [11:0] pk_first = '0, pk_second = '0, duty_nom = '0;
    logic pk_first_vld = 1'b0, pk_second_vld = 1'b0;
    logic [11:0] duty_first, duty_second;

    int checks = 0, errors = 0;
    bit done = 0;
    longint acc_m = 0, corr_m = 0;
    int mode_m = 0, nom_m = 0;

    always #5 clk = ~clk;

    fb_flux_balance u0 (
        .clk(clk), .rst(rst), .conv_en(conv_en), .period_start(period_start),
        .mode_sel(mode_sel), .pk_first(pk_first), .pk_first_vld(pk_first_vld),
        .pk_second(pk_second), .pk_second_vld(pk_second_vld), .duty_nom(duty_nom),
        .duty_first(duty_first), .duty_second(duty_second)
    );

    // pk1, pk2, nominal duty, mode
    localparam int VEC [0:7][0:3] = '{
        '{3000, 1000, 2000, 0}, '{1000, 3000, 2000, 0},
        '{2500, 2500, 1500, 1}, '{4095,    0, 3000, 1},
        '{   0, 4095, 3000, 0}, '{1201, 1200, 1000, 1},
        '{1200, 1201, 1000, 0}, '{3500,  500, 4000, 1}
    };

    function automatic longint clampm(longint v, longint l);
        if (v > l) return l;
        if (v < -l) return -l;
        return v;
    endfunction

    function automatic longint satd(longint v);
        if (v < 0) return 0;
        if (v > 4095) return 4095;
        return v;
    endfunction

    task automatic model_update(int a, int b, int nom);
        longint e, lim, p;
        e = longint'(a - b) >>> 1;
        lim = nom / 20;
        p = (e * KP) >>> FRAC;
        acc_m = clampm(acc_m + e * KI, lim <<< FRAC);
        corr_m = clampm(p + (acc_m >>> FRAC), lim);
    endtask

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_duties(string req);
        longint e1, e2;
        if (mode_m == 0) begin
            e1 = satd(nom_m - (corr_m >>> 1));
            e2 = satd(nom_m + (corr_m >>> 1));
        end else begin
            e1 = nom_m;
            e2 = satd(nom_m + corr_m);
        end
        check({req, " first"}, duty_first, e1);
        check({req, " second"}, duty_second, e2);
    endtask

    task automatic run_period(int a, int b, int nom, int md, bit second);
        @(negedge clk);
        period_start = 1; mode_sel = md[0]; duty_nom = 12'(nom);
        mode_m = md; nom_m = nom;
        @(negedge clk);
        period_start = 0; pk_first = 12'(a); pk_first_vld = 1;
        @(negedge clk);
        pk_first_vld = 0;
        if (second) begin
            pk_second = 12'(b); pk_second_vld = 1;
            @(negedge clk);
            pk_second_vld = 0;
            if (conv_en) model_update(a, b, nom);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        duty_nom = 12'd1800;
        repeat (3) @(negedge clk);
        check("R11 reset first", duty_first, 0);
        check("R11 reset second", duty_second, 0);
        rst = 0; conv_en = 1; nom_m = 1800; mode_m = 0;
        @(negedge clk); @(negedge clk);
        check_duties("R11 after reset");

        // R12: nominal change visible after one edge
        @(negedge clk); duty_nom = 12'd1700; nom_m = 1700;
        @(negedge clk);
        check_duties("R12 nominal latency");

        // R12: correction visible two edges after the second-half strobe
        run_period(1000, 1000, 2000, 0, 0);
        @(negedge clk); period_start = 1; @(negedge clk); period_start = 0;
        pk_first = 12'd3000; pk_first_vld = 1; @(negedge clk); pk_first_vld = 0;
        pk_second = 12'd1000; pk_second_vld = 1; @(negedge clk); pk_second_vld = 0;
        check("R12 not yet first", duty_first, 2000);
        model_update(3000, 1000, 2000);
        @(negedge clk);
        check_duties("R12 two edges");

        // vector table: R1 R3 R6 R7
        for (int i = 0; i < 8; i++) begin
            run_period(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1);
            check_duties($sformatf("R1 R3 R6 R7 vec%0d", i));
        end

        // R2: period closes without second-half sample
        run_period(4000, 0, 2000, 1, 0);
        @(negedge clk); period_start = 1; @(negedge clk); period_start = 0;
        pk_second = 12'd0; pk_second_vld = 1; @(negedge clk); pk_second_vld = 0;
        repeat (3) @(negedge clk);
        check_duties("R2 missing second");
        // R2: second-half sample with nothing pending
        pk_second = 12'd0; pk_second_vld = 1; @(negedge clk); pk_second_vld = 0;
        repeat (3) @(negedge clk);
        check_duties("R2 orphan second");

        // R8: mode_sel change without period start has no effect
        run_period(3000, 1000, 1000, 0, 1);
        @(negedge clk); mode_sel = 1;
        repeat (3) @(negedge clk);
        check_duties("R8 mode held");

        // R10: second duty saturates at full scale
        run_period(4095, 0, 4095, 1, 1);
        check_duties("R10 saturate");
        check("R10 ceiling", duty_second, 4095);

        // R5 R4: windup with small limit, then reversal
        for (int k = 0; k < 300; k++) run_period(4095, 0, 200, 1, 1);
        check_duties("R4 clamp");
        check("R4 clamp value", duty_second, 210);
        run_period(0, 4095, 2000, 1, 1);
        check_duties("R5 antiwindup reversal");
        check("R5 reversal value", duty_second, 1962);

        // R9: disable in same cycle as second-half strobe
        run_period(4095, 0, 2000, 1, 1);
        @(negedge clk); period_start = 1; @(negedge clk); period_start = 0;
        pk_first = 12'd4095; pk_first_vld = 1; @(negedge clk); pk_first_vld = 0;
        pk_second = 12'd0; pk_second_vld = 1; conv_en = 0;
        @(negedge clk); pk_second_vld = 0;
        acc_m = 0; corr_m = 0;
        repeat (3) @(negedge clk);
        check_duties("R9 disable wins");
        run_period(4095, 0, 2000, 1, 1);
        check_duties("R9 ignored while disabled");
        conv_en = 1;
        run_period(3000, 1000, 2000, 0, 1);
        check_duties("R9 restart from zero");

        finish_run();
    end
endmodule